// File: doc/BRIEF.md
# Split Page-Size Translation Buffer

This block caches virtual-to-physical page translations in two fully associative sections searched side by side. One section holds 4 KB mappings and the other holds large mappings of 2 MB or 4 MB. Each lookup port accepts one virtual address per cycle. One cycle later it returns a hit flag, the physical address with the page offset carried over from the virtual address, and a page-size code. Misses are only reported, because page-table walking happens outside the block.

The storage is duplicated, one copy per lookup port, so two translations can complete in the same cycle. A single fill port writes a translation into the section that matches its page size, and every copy is written on the same clock edge. Within a section, a fill takes the lowest-numbered free slot. When the section is full, a round-robin pointer picks the slot to replace. Software keeps the contents coherent through a flush port. The flush port either clears every entry or clears only the entries whose page base address falls inside an inclusive address window.

Top module: `split_tlb`

## Requirements
- R1: After reset every entry is invalid, every lookup misses and no response is valid until a request arrives.
- R2: For each port, rsp_vld_o is high exactly one cycle after lk_vld_i was high. rsp_hit_o, rsp_err_o and the address are meaningful only while it is high. The two ports work independently in every cycle.
- R3: A hit in the 4 KB section returns size code 0 and the physical address {stored frame, va[11:0]}.
- R4: A hit in the large section returns size code 1 for a 2 MB page, with va[20:0] as the offset, or code 2 for a 4 MB page, with va[21:0] as the offset. The bits above the offset come from the filled physical address.
- R5: A fill whose size code is 3 writes nothing.
- R6: A fill updates the copies of both ports on the same edge. A lookup made in the same cycle as a fill sees the contents from before the fill, and a lookup in the next cycle sees the new entry.
- R7: A fill takes the lowest-numbered invalid slot of its section. When the section is full, slots are replaced in round-robin order starting at slot 0, and the pointer advances once per replacement.
- R8: When both sections hit the same address, the large-page result is returned with rsp_err_o high. Otherwise rsp_err_o is low.
- R9: A flush with flush_all_i high invalidates every entry in both sections.
- R10: A flush with flush_all_i low invalidates only the entries whose page base address (the virtual page with its offset bits cleared) lies within [flush_lo_i, flush_hi_i], bounds included.
- R11: When a flush and a fill arrive in the same cycle, the flush acts on the existing entries and the newly filled entry remains valid.
- R12: The 4 KB section holds 16 distinct pages and the large section holds 8, and all of them hit at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_vld_i | input | NUM_PORTS | Lookup request per port |
| lk_va_i | input | NUM_PORTS x VA_W | Virtual address per port |
| rsp_vld_o | output | NUM_PORTS | Response valid, one cycle after the request |
| rsp_hit_o | output | NUM_PORTS | Translation found |
| rsp_pa_o | output | NUM_PORTS x PA_W | Physical address (0 on a miss) |
| rsp_size_o | output | NUM_PORTS x 2 | 0 = 4 KB, 1 = 2 MB, 2 = 4 MB |
| rsp_err_o | output | NUM_PORTS | Both sections hit |
| fill_i | input | 1 | Write one translation |
| fill_vpn_i | input | VA_W-12 | Virtual address bits above bit 11 |
| fill_ppn_i | input | PA_W-12 | Physical address bits above bit 11 |
| fill_size_i | input | 2 | Page size code of the fill (3 is ignored) |
| flush_i | input | 1 | Invalidate entries |
| flush_all_i | input | 1 | With flush_i: invalidate everything |
| flush_lo_i | input | VA_W | Lower bound of the flush window, inclusive |
| flush_hi_i | input | VA_W | Upper bound of the flush window, inclusive |

## Verification
The two collisions that matter are a lookup of an address in the same cycle that it is filled, and a flush in the same cycle as a fill. The bench drives the fill and the lookup of the same page on both ports in one cycle and expects a miss, then expects a hit on the next lookup. It also issues a full flush together with a fill of a new page, then expects the new page to hit while older small and large pages miss. A further case fills a 4 KB page inside an existing 2 MB mapping and checks that the large result wins with the error flag raised.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {
    PG_4K = 2'd0,
    PG_2M = 2'd1,
    PG_4M = 2'd2,
    PG_NA = 2'd3
  } pg_size_e;
endpackage

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int ENTRIES = 16,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ENTRIES-1:0] valid_i,
  input  logic               take_i,
  output logic [IDX_W-1:0]   idx_o
);
  logic [IDX_W-1:0] ptr_q, first;
  logic             free;

  always_comb begin
    free  = 1'b0;
    first = '0;
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (!valid_i[e]) begin
        free  = 1'b1;
        first = IDX_W'(e);
      end
    end
  end

  assign idx_o = free ? first : ptr_q;

  // pointer moves only when a valid entry is displaced
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else if (take_i && !free)
      ptr_q <= (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
  end
endmodule

// File: rtl/tlb_section.sv
module tlb_section #(
  parameter int ENTRIES = 16,
  parameter int COPIES  = 2,
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter bit LARGE   = 1'b0,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_en_i,
  input  logic [IDX_W-1:0]            wr_idx_i,
  input  logic [VA_W-13:0]            wr_vpn_i,
  input  logic [PA_W-13:0]            wr_ppn_i,
  input  logic                        wr_big_i,
  input  logic                        fl_en_i,
  input  logic                        fl_all_i,
  input  logic [VA_W-1:0]             fl_lo_i,
  input  logic [VA_W-1:0]             fl_hi_i,
  input  logic [COPIES-1:0][VA_W-1:0] lk_va_i,
  output logic [COPIES-1:0]           hit_o,
  output logic [COPIES-1:0][PA_W-1:0] pa_o,
  output logic [COPIES-1:0]           big_o,
  output logic [ENTRIES-1:0]          valid_o
);
  localparam int VPN_W = VA_W - 12;
  localparam int PPN_W = PA_W - 12;

  function automatic logic [VPN_W-1:0] vmask(input logic big);
    if (!LARGE)  return '1;
    else if (big) return {VPN_W{1'b1}} << 10;
    else          return {VPN_W{1'b1}} << 9;
  endfunction

  function automatic logic [PA_W-1:0] omask(input logic big);
    if (!LARGE)  return PA_W'(12'hfff);
    else if (big) return PA_W'(22'h3f_ffff);
    else          return PA_W'(21'h1f_ffff);
  endfunction

  for (genvar c = 0; c < COPIES; c++) begin : g_copy
    logic [ENTRIES-1:0]            vld_q, big_q, in_rng;
    logic [ENTRIES-1:0][VPN_W-1:0] vpn_q;
    logic [ENTRIES-1:0][PPN_W-1:0] ppn_q;
    logic                          hit;
    logic [IDX_W-1:0]              sel;

    always_comb begin
      for (int e = 0; e < ENTRIES; e++) begin
        logic [VA_W-1:0] base;
        base      = {vpn_q[e] & vmask(big_q[e]), 12'h000};
        in_rng[e] = (base >= fl_lo_i) && (base <= fl_hi_i);
      end
    end

    // flush acts on old entries, the fill lands afterwards
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q <= '0;
        big_q <= '0;
        vpn_q <= '0;
        ppn_q <= '0;
      end else begin
        for (int e = 0; e < ENTRIES; e++)
          if (fl_en_i && (fl_all_i || in_rng[e])) vld_q[e] <= 1'b0;
        if (wr_en_i) begin
          vld_q[wr_idx_i] <= 1'b1;
          big_q[wr_idx_i] <= wr_big_i;
          vpn_q[wr_idx_i] <= wr_vpn_i;
          ppn_q[wr_idx_i] <= wr_ppn_i;
        end
      end
    end

    // lowest index wins if software left duplicates
    always_comb begin
      hit = 1'b0;
      sel = '0;
      for (int e = ENTRIES - 1; e >= 0; e--) begin
        if (vld_q[e] && (((lk_va_i[c][VA_W-1:12] ^ vpn_q[e]) & vmask(big_q[e])) == '0)) begin
          hit = 1'b1;
          sel = IDX_W'(e);
        end
      end
    end

    assign hit_o[c] = hit;
    assign big_o[c] = hit & big_q[sel];
    assign pa_o[c]  = ({ppn_q[sel], 12'h000} & ~omask(big_q[sel])) |
                      (PA_W'(lk_va_i[c]) & omask(big_q[sel]));
  end

  assign valid_o = g_copy[0].vld_q;
endmodule

// File: rtl/split_tlb.sv
module split_tlb
  import tlb_pkg::*;
#(
  parameter int NUM_PORTS     = 2,
  parameter int VA_W          = 32,
  parameter int PA_W          = 32,
  parameter int SMALL_ENTRIES = 16,
  parameter int LARGE_ENTRIES = 8
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_PORTS-1:0]           lk_vld_i,
  input  logic [NUM_PORTS-1:0][VA_W-1:0] lk_va_i,
  output logic [NUM_PORTS-1:0]           rsp_vld_o,
  output logic [NUM_PORTS-1:0]           rsp_hit_o,
  output logic [NUM_PORTS-1:0][PA_W-1:0] rsp_pa_o,
  output logic [NUM_PORTS-1:0][1:0]      rsp_size_o,
  output logic [NUM_PORTS-1:0]           rsp_err_o,
  input  logic                           fill_i,
  input  logic [VA_W-13:0]               fill_vpn_i,
  input  logic [PA_W-13:0]               fill_ppn_i,
  input  logic [1:0]                     fill_size_i,
  input  logic                           flush_i,
  input  logic                           flush_all_i,
  input  logic [VA_W-1:0]                flush_lo_i,
  input  logic [VA_W-1:0]                flush_hi_i
);
  localparam int SI_W = $clog2(SMALL_ENTRIES);
  localparam int LI_W = $clog2(LARGE_ENTRIES);

  logic wr_s, wr_l, wr_4m;
  logic [SMALL_ENTRIES-1:0] vld_s;
  logic [LARGE_ENTRIES-1:0] vld_l;
  logic [SI_W-1:0] idx_s;
  logic [LI_W-1:0] idx_l;
  logic [NUM_PORTS-1:0] hit_s, hit_l, big_l, unused_big_s;
  logic [NUM_PORTS-1:0][PA_W-1:0] pa_s, pa_l;

  assign wr_s  = fill_i && (fill_size_i == PG_4K);
  assign wr_l  = fill_i && ((fill_size_i == PG_2M) || (fill_size_i == PG_4M));
  assign wr_4m = (fill_size_i == PG_4M);

  tlb_victim #(.ENTRIES(SMALL_ENTRIES)) i_vic_s (
    .clk_i, .rst_ni, .valid_i(vld_s), .take_i(wr_s), .idx_o(idx_s));
  tlb_victim #(.ENTRIES(LARGE_ENTRIES)) i_vic_l (
    .clk_i, .rst_ni, .valid_i(vld_l), .take_i(wr_l), .idx_o(idx_l));

  tlb_section #(
    .ENTRIES(SMALL_ENTRIES), .COPIES(NUM_PORTS), .VA_W(VA_W), .PA_W(PA_W), .LARGE(1'b0)
  ) i_sec_s (
    .clk_i, .rst_ni,
    .wr_en_i(wr_s), .wr_idx_i(idx_s), .wr_vpn_i(fill_vpn_i), .wr_ppn_i(fill_ppn_i),
    .wr_big_i(1'b0),
    .fl_en_i(flush_i), .fl_all_i(flush_all_i), .fl_lo_i(flush_lo_i), .fl_hi_i(flush_hi_i),
    .lk_va_i, .hit_o(hit_s), .pa_o(pa_s), .big_o(unused_big_s), .valid_o(vld_s));

  tlb_section #(
    .ENTRIES(LARGE_ENTRIES), .COPIES(NUM_PORTS), .VA_W(VA_W), .PA_W(PA_W), .LARGE(1'b1)
  ) i_sec_l (
    .clk_i, .rst_ni,
    .wr_en_i(wr_l), .wr_idx_i(idx_l), .wr_vpn_i(fill_vpn_i), .wr_ppn_i(fill_ppn_i),
    .wr_big_i(wr_4m),
    .fl_en_i(flush_i), .fl_all_i(flush_all_i), .fl_lo_i(flush_lo_i), .fl_hi_i(flush_hi_i),
    .lk_va_i, .hit_o(hit_l), .pa_o(pa_l), .big_o(big_l), .valid_o(vld_l));

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_rsp
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rsp_vld_o[p]  <= 1'b0;
        rsp_hit_o[p]  <= 1'b0;
        rsp_err_o[p]  <= 1'b0;
        rsp_pa_o[p]   <= '0;
        rsp_size_o[p] <= PG_4K;
      end else begin
        rsp_vld_o[p] <= lk_vld_i[p];
        rsp_hit_o[p] <= lk_vld_i[p] && (hit_s[p] || hit_l[p]);
        rsp_err_o[p] <= lk_vld_i[p] && hit_s[p] && hit_l[p];
        if (lk_vld_i[p] && hit_l[p]) begin
          rsp_pa_o[p]   <= pa_l[p];
          rsp_size_o[p] <= big_l[p] ? PG_4M : PG_2M;
        end else if (lk_vld_i[p] && hit_s[p]) begin
          rsp_pa_o[p]   <= pa_s[p];
          rsp_size_o[p] <= PG_4K;
        end else begin
          rsp_pa_o[p]   <= '0;
          rsp_size_o[p] <= PG_4K;
        end
      end
    end
  end
endmodule

// File: rtl/split_tlb_chk.sv
module split_tlb_chk #(
  parameter int NUM_PORTS = 2,
  parameter int VA_W      = 32,
  parameter int PA_W      = 32
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic [NUM_PORTS-1:0]           lk_vld_i,
  input logic [NUM_PORTS-1:0][VA_W-1:0] lk_va_i,
  input logic [NUM_PORTS-1:0]           rsp_vld_o,
  input logic [NUM_PORTS-1:0]           rsp_hit_o,
  input logic [NUM_PORTS-1:0][PA_W-1:0] rsp_pa_o,
  input logic [NUM_PORTS-1:0][1:0]      rsp_size_o,
  input logic [NUM_PORTS-1:0]           rsp_err_o,
  input logic                           fill_i,
  input logic                           flush_i,
  input logic                           flush_all_i
);
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    AST_RSP_TRACKS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rsp_vld_o[p] == $past(lk_vld_i[p])); // R2
    AST_HIT_NEEDS_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rsp_hit_o[p] |-> rsp_vld_o[p]); // R2
    AST_ERR_LARGE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rsp_err_o[p] |-> (rsp_hit_o[p] && rsp_size_o[p] != 2'd0)); // R8
    AST_SMALL_OFFSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lk_vld_i[p]) |=> ((rsp_hit_o[p] && rsp_size_o[p] == 2'd0) ->
        rsp_pa_o[p][11:0] == $past(lk_va_i[p][11:0]))); // R3
    AST_LARGE_OFFSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lk_vld_i[p]) |=> ((rsp_hit_o[p] && rsp_size_o[p] == 2'd1) ->
        rsp_pa_o[p][20:0] == $past(lk_va_i[p][20:0]))); // R4
    AST_FLUSH_ALL_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flush_i && flush_all_i && !fill_i) |=> (lk_vld_i[p] |=> !rsp_hit_o[p])); // R9
  end

  if (NUM_PORTS >= 2) begin : g_dual
    AST_COPIES_AGREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lk_vld_i[0] && lk_vld_i[1] && lk_va_i[0] == lk_va_i[1]) |=>
        (rsp_hit_o[0] == rsp_hit_o[1] && rsp_pa_o[0] == rsp_pa_o[1])); // R6
  end
endmodule

bind split_tlb split_tlb_chk #(
  .NUM_PORTS(NUM_PORTS), .VA_W(VA_W), .PA_W(PA_W)
) i_split_tlb_chk (.*);

// File: tb/test_split_tlb.sv
module test_split_tlb;
  logic clk_i = 1'b0;
  logic rst_ni;
  logic [1:0]       lk_vld_i;
  logic [1:0][31:0] lk_va_i;
  logic [1:0]       rsp_vld_o, rsp_hit_o, rsp_err_o;
  logic [1:0][31:0] rsp_pa_o;
  logic [1:0][1:0]  rsp_size_o;
  logic             fill_i;
  logic [19:0]      fill_vpn_i, fill_ppn_i;
  logic [1:0]       fill_size_i;
  logic             flush_i, flush_all_i;
  logic [31:0]      flush_lo_i, flush_hi_i;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk_i = ~clk_i;

  split_tlb i_split_tlb (.*);

  function automatic logic [31:0] sva(int i); return 32'h1000_0000 + (i << 12); endfunction
  function automatic logic [31:0] spa(int i); return 32'h8000_0000 + (((i * 7 + 3) & 'hff) << 12); endfunction
  function automatic logic [31:0] soff(int i); return (i * 293 + 5) & 'hfff; endfunction
  function automatic logic [31:0] lva(int j);
    return (j < 4) ? 32'h4000_0000 + (j << 21) : 32'h6000_0000 + ((j - 4) << 22);
  endfunction
  function automatic logic [31:0] lpa(int j);
    return (j < 4) ? 32'hC000_0000 + ((3 - j) << 21) : 32'hA000_0000 + (j << 22);
  endfunction
  function automatic logic [31:0] loff(int j);
    return (j < 4) ? ((j * 32'h5a5a5 + 32'h123) & 32'h1f_ffff) : ((j * 32'h5a5a5 + 32'h123) & 32'h3f_ffff);
  endfunction

  task automatic idle();
    lk_vld_i = '0; lk_va_i = '0; fill_i = 0; fill_vpn_i = '0; fill_ppn_i = '0;
    fill_size_i = 2'd0; flush_i = 0; flush_all_i = 0; flush_lo_i = '0; flush_hi_i = '0;
  endtask

  task automatic tick(); @(negedge clk_i); endtask

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_fill(input logic [31:0] va, input logic [31:0] pa, input logic [1:0] sz);
    fill_i = 1; fill_vpn_i = va[31:12]; fill_ppn_i = pa[31:12]; fill_size_i = sz;
  endtask

  task automatic do_fill(input logic [31:0] va, input logic [31:0] pa, input logic [1:0] sz);
    idle(); set_fill(va, pa, sz); tick();
  endtask

  task automatic do_flush(input bit all, input logic [31:0] lo, input logic [31:0] hi);
    idle(); flush_i = 1; flush_all_i = all; flush_lo_i = lo; flush_hi_i = hi; tick();
  endtask

  // checks both ports after a request presented one cycle earlier
  task automatic judge(input string req, input bit h, input logic [31:0] pa,
                       input logic [1:0] sz, input bit er);
    for (int p = 0; p < 2; p++) begin
      chk(rsp_vld_o[p] == 1'b1, req, rsp_vld_o[p], 1);
      chk(rsp_hit_o[p] == h, req, rsp_hit_o[p], h);
      if (h) begin
        chk(rsp_pa_o[p] == pa, req, rsp_pa_o[p], pa);
        chk(rsp_size_o[p] == sz, req, rsp_size_o[p], sz);
        chk(rsp_err_o[p] == er, req, rsp_err_o[p], er);
      end
    end
  endtask

  task automatic look(input logic [31:0] va, input string req, input bit h,
                      input logic [31:0] pa, input logic [1:0] sz, input bit er);
    idle(); lk_vld_i = 2'b11; lk_va_i[0] = va; lk_va_i[1] = va; tick();
    judge(req, h, pa, sz, er);
  endtask

  initial begin
    idle();
    rst_ni = 1'b0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    tick();
    chk(rsp_vld_o == 2'b00, "R1 idle", rsp_vld_o, 0);
    look(sva(0), "R1 empty", 0, 0, 0, 0);

    // R5: reserved size writes nothing
    do_fill(32'h7000_0000, 32'h1111_1000, 2'd3);
    chk(rsp_vld_o == 2'b00, "R2 no request", rsp_vld_o, 0);
    look(32'h7000_0abc, "R5 size3", 0, 0, 0, 0);

    // R3 R12: fill and sweep the small section
    for (int i = 0; i < 16; i++) do_fill(sva(i), spa(i), 2'd0);
    for (int i = 0; i < 16; i++) look(sva(i) | soff(i), "R3 small", 1, spa(i) | soff(i), 2'd0, 0);

    // R4 R12: large section, 2 MB then 4 MB pages
    for (int j = 0; j < 8; j++) do_fill(lva(j), lpa(j), (j < 4) ? 2'd1 : 2'd2);
    for (int j = 0; j < 8; j++)
      look(lva(j) | loff(j), "R4 large", 1, lpa(j) | loff(j), (j < 4) ? 2'd1 : 2'd2, 0);
    for (int i = 0; i < 16; i++) look(sva(i) | 32'h7ff, "R12 coexist", 1, spa(i) | 32'h7ff, 2'd0, 0);

    // R2: ports independent with different addresses
    idle(); lk_vld_i = 2'b01; lk_va_i[0] = sva(3); lk_va_i[1] = lva(5); tick();
    chk(rsp_vld_o == 2'b01, "R2 port mask", rsp_vld_o, 2'b01);
    chk(rsp_pa_o[0] == spa(3), "R2 port0", rsp_pa_o[0], spa(3));
    idle(); lk_vld_i = 2'b11; lk_va_i[0] = sva(9); lk_va_i[1] = lva(5) | 32'h2a_0001; tick();
    chk(rsp_pa_o[0] == spa(9), "R2 port0 b", rsp_pa_o[0], spa(9));
    chk(rsp_pa_o[1] == (lpa(5) | 32'h2a_0001), "R2 port1", rsp_pa_o[1], lpa(5) | 32'h2a_0001);
    chk(rsp_size_o[1] == 2'd2, "R4 size 4M", rsp_size_o[1], 2);

    // R6: fill and lookup of the same page in one cycle
    idle(); set_fill(32'h2000_0000, 32'h9000_0000, 2'd0);
    lk_vld_i = 2'b11; lk_va_i[0] = 32'h2000_0044; lk_va_i[1] = 32'h2000_0044; tick();
    judge("R6 same cycle miss", 0, 0, 0, 0);
    look(32'h2000_0044, "R6 next cycle hit", 1, 32'h9000_0044, 2'd0, 0);
    // R7: full section, round robin from slot 0
    look(sva(0), "R7 slot0 evicted", 0, 0, 0, 0);
    look(sva(1), "R7 slot1 kept", 1, spa(1), 2'd0, 0);
    do_fill(32'h2000_1000, 32'h9000_1000, 2'd0);
    look(sva(1), "R7 slot1 evicted", 0, 0, 0, 0);
    look(sva(2), "R7 slot2 kept", 1, spa(2), 2'd0, 0);

    // R8: small page inside a 2 MB mapping (evicts slot 2)
    do_fill(32'h4000_5000, 32'h1234_5000, 2'd0);
    look(32'h4000_5123, "R8 overlap", 1, lpa(0) | 32'h5123, 2'd1, 1);
    look(sva(2), "R7 slot2 evicted", 0, 0, 0, 0);

    // R10: range flush of small pages 3..5 and one large page
    do_flush(0, sva(3), sva(5));
    for (int i = 3; i < 6; i++) look(sva(i), "R10 in range", 0, 0, 0, 0);
    look(sva(6), "R10 above range", 1, spa(6), 2'd0, 0);
    look(32'h2000_1000, "R10 outside", 1, 32'h9000_1000, 2'd0, 0);
    do_flush(0, lva(1), lva(1));
    look(lva(1) | 32'h10, "R10 large hit range", 0, 0, 0, 0);
    look(lva(0) | 32'h10, "R10 large below", 1, lpa(0) | 32'h10, 2'd1, 0);
    look(lva(2) | 32'h10, "R10 large above", 1, lpa(2) | 32'h10, 2'd1, 0);

    // R7: freed slots refilled before any eviction
    for (int k = 0; k < 3; k++) do_fill(32'h3000_0000 + (k << 12), 32'h7700_0000 + (k << 12), 2'd0);
    for (int i = 6; i < 16; i++) look(sva(i), "R7 invalid first", 1, spa(i), 2'd0, 0);
    look(32'h3000_2fff, "R7 refill", 1, 32'h7700_2fff, 2'd0, 0);

    // R11 R9: full flush with simultaneous fill
    idle(); flush_i = 1; flush_all_i = 1; set_fill(32'h5000_0000, 32'h6600_0000, 2'd0); tick();
    look(32'h5000_0321, "R11 fill survives", 1, 32'h6600_0321, 2'd0, 0);
    look(sva(6), "R9 small gone", 0, 0, 0, 0);
    look(lva(0), "R9 large gone", 0, 0, 0, 0);
    look(lva(6), "R9 large 4M gone", 0, 0, 0, 0);
    do_flush(1, 0, 0);
    look(32'h5000_0321, "R9 all gone", 0, 0, 0, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule